// File: doc/BRIEF.md
# Timestamped Run-Length Sample Cluster Writer

This block turns a strobed stream of 16-bit sample words into compact records in a linear, word-addressed sample memory. A record, called a cluster, is eight words long. The first word is a timestamp. The other seven are the sample words of seven consecutive ticks, starting at that timestamp. While the sampled levels hold steady, nothing is stored. A new cluster opens only when a sample differs from the one before it, or when the 16-bit timestamp has come round to zero. The second rule ensures that a reader can always rebuild absolute time from the stored timestamps.

Software or a sequencer pulses `cap_start` to begin a capture. `cap_start` clears the timestamp, the write position and every status flag, from any state. A `trig_in` pulse records the write position at that moment. A `cap_stop` pulse lets the cluster in progress finish, then freezes the block and records the stop position. Each position is a word address. The upper `ROW_W` bits give the row and the lower 9 bits give the word within a 512-word row of 64 clusters.

The controller is a five-state machine:
- ST_IDLE: before the first start.
- ST_WATCH: capturing, no cluster open.
- ST_LEAD: the timestamp word has just been issued and the first sample word goes out now.
- ST_FILL: the remaining six slots are filling.
- ST_DONE: stopped.

The transitions are:
- start: any state to ST_WATCH.
- open: ST_WATCH to ST_LEAD.
- lead: ST_LEAD to ST_FILL.
- close: ST_FILL to ST_WATCH, taken on the seventh slot.
- finish: ST_FILL to ST_DONE on the seventh slot with a stop pending, and ST_WATCH to ST_DONE when a stop is pending.

Top module: `rle_cluster_writer`

## Requirements
- R1: After reset, and until the first `cap_start`, `mem_we` stays low, `wr_pos` is 0 and `done`, `wrapped` and `trig_hit` are low. `cap_stop`, `trig_in` and `sample_tick` pulses in that period have no effect on any output.
- R2: A cluster occupies eight consecutive addresses A..A+7. Word A holds the timestamp T of the tick that opened the cluster. Word A+i (i = 1..7) holds the sample of the tick whose timestamp is T+i-1.
- R3: With no cluster open, a tick whose sample equals the previous accepted tick's sample writes nothing, unless R5 forces a cluster.
- R4: Once a cluster is open, the next six accepted ticks fill its slots whatever their values. After the seventh slot, the first tick whose sample differs opens a new cluster stamped with that tick's own timestamp.
- R5: The timestamp is a 16-bit counter. `cap_start` clears it, and each accepted tick advances it by 1. A tick with timestamp 0 and no cluster open opens a cluster; this is why the first tick after start always opens one. If timestamp 0 passes while a cluster is filling, the next tick with no cluster open opens one even if the sample has not changed.
- R6: `mem_addr` of every write equals the `wr_pos` shown in the cycle before it. Each write advances `wr_pos` by 1. Positions are {row, 9-bit word-in-row}.
- R7: A write to the last address makes `wr_pos` wrap to 0 and sets `wrapped`. `wrapped` stays set until the next `cap_start`, which clears it.
- R8: The first `trig_in` pulse during a capture copies `wr_pos` into `trig_pos` and sets `trig_hit`. Later pulses leave both unchanged until `cap_start` clears them.
- R9: `cap_stop` during a capture lets the open cluster complete, then raises `done`. At that point `stop_pos` equals `wr_pos`, the next free address. After that, ticks write nothing.
- R10: `sample_tick` is never high in two consecutive cycles, so each tick is followed by a free cycle on the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_start | input | 1 | Pulse: clear state and begin capture |
| cap_stop | input | 1 | Pulse: stop after the open cluster |
| sample_tick | input | 1 | One-cycle strobe marking a sample period |
| sample_in | input | 16 | Sample word, valid with `sample_tick` |
| trig_in | input | 1 | Trigger event pulse |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ROW_W+9 | Memory word address |
| mem_data | output | 16 | Memory write data |
| wr_pos | output | ROW_W+9 | Next address to be written |
| trig_pos | output | ROW_W+9 | Write position at the first trigger |
| trig_hit | output | 1 | A trigger has been recorded |
| stop_pos | output | ROW_W+9 | Write position when capture ended |
| done | output | 1 | Capture has ended |
| wrapped | output | 1 | Sticky: write position has wrapped |

## Verification
The bench drives sample streams that tell the cluster-opening rules apart:
- A long constant run must produce one cluster only.
- A run of all-different words must fill a cluster with no premature reopen.
- A repeat straight after a full cluster must not reopen.
- A later change must open a cluster carrying its own timestamp.
- A run of all-distinct words packs clusters back to back until the address space wraps.
- A 65541-tick constant stream with one change just before rollover separates the two forced-cluster cases: timestamp 0 seen while idle, and timestamp 0 passing inside a filling cluster.

Trigger and stop pulses are placed mid-cluster and repeated, to show they latch once and let the cluster finish.

// File: rtl/rlcw_pkg.sv
package rlcw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WATCH,
        ST_LEAD,
        ST_FILL,
        ST_DONE
    } cw_state_t;

endpackage

// File: rtl/rlcw_timebase.sv
// Free-running cluster timestamp, advanced once per accepted sample tick.
module rlcw_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] ts,
    output logic         ts_zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts <= '0;
        end else if (clr) begin
            ts <= '0;
        end else if (adv) begin
            ts <= ts + 1'b1;
        end
    end

    assign ts_zero = (ts == '0);

endmodule

// File: rtl/rlcw_change_det.sv
// Remembers the last accepted sample and flags a difference on the input.
module rlcw_change_det #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         differs
);

    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (load) begin
            last_q <= din;
        end
    end

    assign differs = (din != last_q);

endmodule

// File: rtl/rlcw_addr_gen.sv
// Linear write position with wrap to zero and a sticky wrap flag.
module rlcw_addr_gen #(
    parameter int POS_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_after,
    output logic             wrapped
);

    localparam logic [POS_W-1:0] POS_LAST = {POS_W{1'b1}};

    assign pos_after = adv ? pos + 1'b1 : pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos     <= '0;
            wrapped <= 1'b0;
        end else if (clr) begin
            pos     <= '0;
            wrapped <= 1'b0;
        end else if (adv) begin
            pos <= pos + 1'b1;
            if (pos == POS_LAST) begin
                wrapped <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rle_cluster_writer.sv
module rle_cluster_writer
    import rlcw_pkg::*;
#(
    parameter int WORD_W           = 16,
    parameter int SLOTS            = 7,
    parameter int CLUSTERS_PER_ROW = 64,
    parameter int ROW_W            = 15
) (
    input  logic                                                      clk,
    input  logic                                                      rst_n,
    input  logic                                                      cap_start,
    input  logic                                                      cap_stop,
    input  logic                                                      sample_tick,
    input  logic [WORD_W-1:0]                                         sample_in,
    input  logic                                                      trig_in,
    output logic                                                      mem_we,
    output logic [ROW_W+$clog2(CLUSTERS_PER_ROW*(SLOTS+1))-1:0]       mem_addr,
    output logic [WORD_W-1:0]                                         mem_data,
    output logic [ROW_W+$clog2(CLUSTERS_PER_ROW*(SLOTS+1))-1:0]       wr_pos,
    output logic [ROW_W+$clog2(CLUSTERS_PER_ROW*(SLOTS+1))-1:0]       trig_pos,
    output logic                                                      trig_hit,
    output logic [ROW_W+$clog2(CLUSTERS_PER_ROW*(SLOTS+1))-1:0]       stop_pos,
    output logic                                                      done,
    output logic                                                      wrapped
);

    localparam int EVT_W = $clog2(CLUSTERS_PER_ROW * (SLOTS + 1));
    localparam int POS_W = ROW_W + EVT_W;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    cw_state_t state_q, state_d;

    logic [WORD_W-1:0] ts;
    logic              ts_zero;
    logic              differs;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  pos_after;

    logic [CNT_W-1:0]  slot_cnt;
    logic [WORD_W-1:0] lead_word;
    logic              stop_pend;
    logic              roll_due;

    logic in_capture;
    logic tick_acc;
    logic stop_req;
    logic open_now;
    logic fill_tick;
    logic last_slot;
    logic issue;

    // Ticks only count in the two states where the port is free for them.
    assign in_capture = (state_q == ST_WATCH) || (state_q == ST_FILL);
    assign tick_acc   = sample_tick && in_capture && !cap_start;
    assign stop_req   = cap_stop || stop_pend;

    // A cluster opens on a changed sample, at timestamp zero, or when a
    // rollover slipped by inside the previous cluster.
    assign open_now  = (state_q == ST_WATCH) && !cap_start && !stop_req &&
                       sample_tick && (differs || ts_zero || roll_due);
    assign fill_tick = (state_q == ST_FILL) && sample_tick && !cap_start;
    assign last_slot = fill_tick && (slot_cnt == LAST_SLOT);
    assign issue     = open_now || fill_tick ||
                       ((state_q == ST_LEAD) && !cap_start);

    rlcw_timebase #(
        .W (WORD_W)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cap_start),
        .adv     (tick_acc),
        .ts      (ts),
        .ts_zero (ts_zero)
    );

    rlcw_change_det #(
        .W (WORD_W)
    ) u_change (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tick_acc),
        .din     (sample_in),
        .differs (differs)
    );

    rlcw_addr_gen #(
        .POS_W (POS_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cap_start),
        .adv       (issue),
        .pos       (pos),
        .pos_after (pos_after),
        .wrapped   (wrapped)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (cap_start) begin
            state_d = ST_WATCH;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WATCH: begin
                    if (stop_req) begin
                        state_d = ST_DONE;
                    end else if (open_now) begin
                        state_d = ST_LEAD;
                    end
                end
                ST_LEAD:  state_d = ST_FILL;
                ST_FILL: begin
                    if (last_slot) begin
                        state_d = stop_req ? ST_DONE : ST_WATCH;
                    end
                end
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs and per-capture bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            lead_word <= '0;
            slot_cnt  <= '0;
            stop_pend <= 1'b0;
            roll_due  <= 1'b0;
            trig_hit  <= 1'b0;
            trig_pos  <= '0;
            stop_pos  <= '0;
        end else begin
            mem_we <= issue;
            if (issue) begin
                mem_addr <= pos;
            end

            if (open_now) begin
                mem_data  <= ts;
                lead_word <= sample_in;
            end else if (state_q == ST_LEAD) begin
                mem_data <= lead_word;
            end else if (fill_tick) begin
                mem_data <= sample_in;
            end

            if (cap_start) begin
                slot_cnt  <= '0;
                stop_pend <= 1'b0;
                roll_due  <= 1'b0;
                trig_hit  <= 1'b0;
                trig_pos  <= '0;
                stop_pos  <= '0;
            end else begin
                if (state_q == ST_LEAD) begin
                    slot_cnt <= CNT_W'(1);
                end else if (fill_tick) begin
                    slot_cnt <= slot_cnt + 1'b1;
                end

                if (cap_stop && (in_capture || state_q == ST_LEAD)) begin
                    stop_pend <= 1'b1;
                end

                if (open_now) begin
                    roll_due <= 1'b0;
                end else if (tick_acc && ts_zero && state_q == ST_FILL) begin
                    roll_due <= 1'b1;
                end

                if (trig_in && !trig_hit &&
                    (in_capture || state_q == ST_LEAD)) begin
                    trig_hit <= 1'b1;
                    trig_pos <= pos;
                end

                if (state_d == ST_DONE && state_q != ST_DONE) begin
                    stop_pos <= pos_after;
                end
            end
        end
    end

    assign wr_pos = pos;
    assign done   = (state_q == ST_DONE);

endmodule

// File: rtl/rlcw_checker.sv
module rlcw_checker #(
    parameter int POS_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_start,
    input logic             sample_tick,
    input logic             mem_we,
    input logic [POS_W-1:0] mem_addr,
    input logic [POS_W-1:0] wr_pos,
    input logic             wrapped,
    input logic             trig_hit,
    input logic [POS_W-1:0] trig_pos,
    input logic             done,
    input logic [POS_W-1:0] stop_pos
);

    logic started;
    logic we_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started <= 1'b0;
            we_seen <= 1'b0;
        end else begin
            if (cap_start) started <= 1'b1;
            we_seen <= 1'b1;
        end
    end

    assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> !mem_we);

    assert_write_at_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_seen && mem_we) |-> mem_addr == $past(wr_pos));

    assert_back_to_back_consecutive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_seen && mem_we && $past(mem_we)) |-> mem_addr == POS_W'($past(mem_addr) + 1'b1));

    assert_wrap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrapped && !cap_start) |=> wrapped);

    assert_trigger_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && !cap_start) |=> (trig_hit && $stable(trig_pos)));

    assert_stop_pos_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> stop_pos == wr_pos);

    assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_start) |=> !mem_we);

    assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> !sample_tick);

endmodule

bind rle_cluster_writer rlcw_checker #(
    .POS_W (POS_W)
) u_rlcw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_start   (cap_start),
    .sample_tick (sample_tick),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .wr_pos      (wr_pos),
    .wrapped     (wrapped),
    .trig_hit    (trig_hit),
    .trig_pos    (trig_pos),
    .done        (done),
    .stop_pos    (stop_pos)
);

// File: tb/rle_cluster_writer_test.sv
`timescale 1ns/1ps
module rle_cluster_writer_test;

    localparam int ROW_W = 1;
    localparam int POS_W = ROW_W + 9;
    localparam int DEPTH = 1 << POS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_start = 1'b0;
    logic              cap_stop = 1'b0;
    logic              sample_tick = 1'b0;
    logic [15:0]       sample_in = '0;
    logic              trig_in = 1'b0;
    logic              mem_we;
    logic [POS_W-1:0]  mem_addr;
    logic [15:0]       mem_data;
    logic [POS_W-1:0]  wr_pos;
    logic [POS_W-1:0]  trig_pos;
    logic              trig_hit;
    logic [POS_W-1:0]  stop_pos;
    logic              done;
    logic              wrapped;

    int n_chk = 0;
    int n_err = 0;
    int n_wr  = 0;
    bit finished = 0;
    logic [15:0] bmem [DEPTH];

    always #4 clk = ~clk;

    rle_cluster_writer #(.ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_stop(cap_stop),
        .sample_tick(sample_tick), .sample_in(sample_in), .trig_in(trig_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .wr_pos(wr_pos), .trig_pos(trig_pos), .trig_hit(trig_hit),
        .stop_pos(stop_pos), .done(done), .wrapped(wrapped)
    );

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            bmem[mem_addr] <= mem_data;
            n_wr <= n_wr + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_word(input logic [15:0] v);
        @(negedge clk);
        sample_tick = 1'b1;
        sample_in   = v;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); cap_start = 1'b1;
        @(negedge clk); cap_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); cap_stop = 1'b1;
        @(negedge clk); cap_stop = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk("R1 reset mem_we", mem_we, 0);
        chk("R1 reset wr_pos", wr_pos, 0);
        chk("R1 reset done", done, 0);
        chk("R1 reset wrapped", wrapped, 0);
        chk("R1 reset trig_hit", trig_hit, 0);
    endtask

    task automatic t_before_start();
        pulse_stop();
        pulse_trig();
        tick_word(16'h0042);
        tick_word(16'h0043);
        idle(3);
        chk("R1 idle writes", n_wr, 0);
        chk("R1 idle wr_pos", wr_pos, 0);
        chk("R1 idle done", done, 0);
        chk("R1 idle trig_hit", trig_hit, 0);
    endtask

    task automatic t_main();
        pulse_start();
        for (int k = 0; k < 20; k++) tick_word(16'hA5A5);
        idle(3);
        chk("R3 constant run wr_pos", wr_pos, 8);
        chk("R5 first header ts", bmem[0], 0);
        chk("R2 first slot", bmem[1], 16'hA5A5);
        chk("R2 last slot", bmem[7], 16'hA5A5);
        for (int k = 20; k < 27; k++) tick_word(16'(k - 19));
        idle(3);
        chk("R2 second header ts", bmem[8], 20);
        chk("R4 slot values differ", bmem[12], 4);
        chk("R4 full cluster wr_pos", wr_pos, 16);
        tick_word(16'd7);
        idle(3);
        chk("R3 repeat after cluster", wr_pos, 16);
        for (int k = 28; k < 35; k++) tick_word(16'd9);
        idle(3);
        chk("R4 new cluster own ts", bmem[16], 28);
        chk("R4 unchanged slot kept", bmem[23], 9);
        chk("R6 wr_pos after three", wr_pos, 24);
        pulse_trig();
        idle(1);
        chk("R8 trig_hit set", trig_hit, 1);
        chk("R8 trig_pos", trig_pos, 24);
        tick_word(16'd9);
        tick_word(16'd10);
        idle(2);
        pulse_trig();
        idle(1);
        chk("R8 second trigger ignored", trig_pos, 24);
        pulse_stop();
        for (int k = 37; k < 42; k++) tick_word(16'd10);
        idle(2);
        chk("R9 done waits for cluster", done, 0);
        tick_word(16'd42);
        idle(2);
        chk("R9 done after cluster", done, 1);
        chk("R9 stop_pos", stop_pos, 32);
        chk("R9 last slot written", bmem[31], 42);
        chk("R2 stopped header ts", bmem[24], 36);
        tick_word(16'd99);
        idle(3);
        chk("R9 no write after done", wr_pos, 32);
    endtask

    task automatic t_wrap();
        pulse_start();
        idle(1);
        chk("R8 start clears trig_hit", trig_hit, 0);
        chk("R9 start clears done", done, 0);
        chk("R6 start clears wr_pos", wr_pos, 0);
        for (int k = 0; k < 895; k++) tick_word(16'(k));
        idle(3);
        chk("R7 not yet wrapped", wrapped, 0);
        chk("R6 position before wrap", wr_pos, DEPTH - 1);
        tick_word(16'd895);
        idle(3);
        chk("R7 wrapped set", wrapped, 1);
        chk("R7 wr_pos wrapped", wr_pos, 0);
        tick_word(16'd896);
        idle(3);
        chk("R7 header at zero", bmem[0], 896);
        chk("R7 wrapped sticky", wrapped, 1);
        pulse_start();
        idle(1);
        chk("R7 start clears wrapped", wrapped, 0);
    endtask

    task automatic t_rollover();
        for (int k = 0; k < 65533; k++) tick_word(16'h1234);
        idle(3);
        chk("R3 long constant run", wr_pos, 8);
        chk("R5 start header", bmem[0], 0);
        for (int k = 65533; k < 65540; k++) tick_word(16'h5678);
        idle(3);
        chk("R5 header before rollover", bmem[8], 16'hFFFD);
        chk("R2 slot at ts zero", bmem[12], 16'h5678);
        chk("R5 no write after fill", wr_pos, 16);
        tick_word(16'h5678);
        idle(3);
        chk("R5 forced header", bmem[16], 4);
        chk("R5 forced lead slot", bmem[17], 16'h5678);
        chk("R5 forced wr_pos", wr_pos, 18);
    endtask

    initial begin
        t_reset();
        t_before_start();
        t_main();
        t_wrap();
        t_rollover();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 run did not complete actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule